// File: doc/BRIEF.md
# SEC-DED Read-Path Decoder for a 72-Bit Memory Word

This block sits on the read path of a memory that stores 64 data bits together with 8 check bits. On each cycle that a read word arrives with its valid strobe, the block works out an 8-bit syndrome from a fixed parity-check matrix. If the syndrome points at exactly one bit of the word, that bit is repaired. Any other nonzero syndrome is flagged as uncorrectable. One clock later it presents the data, a correctable flag, an uncorrectable flag, the raw syndrome and the index of the repaired bit.

Every column of the matrix has odd weight. A single flipped bit therefore always leaves an odd-weight syndrome, and any two flipped bits always leave an even-weight syndrome that no column can match. The raw syndrome is brought out so that software can map it back to a bit position on its own. A companion encoder function in the package produces the check byte for the write path.

Top module: `ecc72_decoder`

## Requirements
- R1: The word layout is bits 63:0 for data and bits 71:64 for check bits. Word bit 64+j carries the one-hot syndrome column 8'h80 >> j, so bit 64 maps to 8'h80 and bit 71 maps to 8'h01.
- R2: Data bit i carries a fixed syndrome column. Listed in groups of eight, starting from bit 0: f4 f1 ec ea e9 e6 e5 e3 / dc da d9 d6 d5 d3 ce cb / b5 b0 ad ab a8 a7 a4 a2 / 9d 9b 98 97 94 92 8f 8a / 75 70 6d 6b 68 67 64 62 / 5e 5b 58 57 54 52 4f 4a / 34 31 2c 2a 29 26 25 23 / 1c 1a 19 16 15 13 0e 0b. A word with only data bit i corrupted reports that value as its syndrome.
- R3: The syndrome output is the XOR of the columns of all set bits in the received word. A word whose check bits were made by the encoder rule (check bit 64+j is the parity of the data bits whose column has bit 7-j set) gives a syndrome of zero.
- R4: A zero syndrome passes the data through unchanged, with both flags low and a reported bit index of 0.
- R5: A syndrome equal to the column of data bit i inverts data bit i, raises the correctable flag and reports index i.
- R6: A syndrome equal to the column of check bit 64+j leaves the data unchanged, raises the correctable flag and reports index 64+j.
- R7: Any other nonzero syndrome raises the uncorrectable flag, keeps the correctable flag low, passes the received data unmodified and reports index 0. Every double-bit error falls into this case, and so does flipping bits 1, 2 and 3 of a clean 0x0101010101010101 word.
- R8: Results appear on the clock edge after the edge that samples the valid input, with the output valid high. The output valid is low after a cycle with no valid input, and the other outputs then hold their last values.
- R9: After reset, the output valid, data, both flags, the syndrome and the index are all zero.
- R10: A clean 0x0101010101010101 word with only bit 0 flipped reads back as 0x0101010101010101, with the correctable flag high and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Read word present this cycle |
| in_word | input | 72 | Received word: data in 63:0, check bits in 71:64 |
| out_valid | output | 1 | Decoded result present |
| out_data | output | 64 | Corrected data, or the raw data when the word is uncorrectable |
| out_corr | output | 1 | A single-bit error was repaired |
| out_uncorr | output | 1 | The error cannot be repaired |
| out_syndrome | output | 8 | Raw syndrome |
| out_pos | output | 7 | Index of the repaired bit (0 to 71) |

## Verification
The bench builds the block with the package's only configuration: 64 data bits and 8 check bits. Because this word is small, the bench can flip every one of the 72 positions on six data patterns. It can also flip every one of the 2556 bit pairs on two patterns, which reaches each column comparator and every even-weight syndrome that a double error can produce. The expected syndrome and class are computed in the bench from its own copy of the column list, together with the two stated example words and a hold check while the valid input is idle.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int POS_W  = $clog2(WORD_W);

    typedef logic [CHK_W-1:0]  syn_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    // Parity-check columns for the data bits, bit 0 first; all odd weight.
    localparam syn_t DATA_COLS [DATA_W] = '{
        8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
        8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
        8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
        8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
        8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
        8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b
    };

    // Column of any word position; check positions are one-hot, MSB first.
    function automatic syn_t word_col(input int idx);
        syn_t c;
        if (idx < DATA_W) c = DATA_COLS[idx];
        else              c = syn_t'(1) << (CHK_W - 1 - (idx - DATA_W));
        return c;
    endfunction

    // Row k of the parity-check matrix as a mask over the whole word.
    function automatic word_t row_mask(input int k);
        word_t m;
        syn_t  c;
        for (int i = 0; i < WORD_W; i++) begin
            c    = word_col(i);
            m[i] = c[k];
        end
        return m;
    endfunction

    // Write-path encoder: check byte placed so the full word has zero syndrome.
    function automatic syn_t encode_check(input data_t d);
        syn_t  chk;
        word_t m;
        for (int j = 0; j < CHK_W; j++) begin
            m      = row_mask(CHK_W - 1 - j);
            chk[j] = ^(d & m[DATA_W-1:0]);
        end
        return chk;
    endfunction

    typedef struct packed {
        logic  vld;
        data_t data;
        logic  corr;
        logic  unc;
        syn_t  syn;
        pos_t  pos;
    } dec_state_t;

endpackage

// File: rtl/ecc72_syndrome.sv
module ecc72_syndrome
    import ecc72_pkg::*;
(
    input  word_t word_i,
    output syn_t  syn_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_row
        localparam word_t ROW_MASK = row_mask(k);
        assign syn_o[k] = ^(word_i & ROW_MASK);
    end

endmodule

// File: rtl/ecc72_locate.sv
module ecc72_locate
    import ecc72_pkg::*;
(
    input  syn_t  syn_i,
    output word_t flip_o,
    output pos_t  pos_o,
    output logic  corr_o,
    output logic  unc_o
);

    word_t hit;

    for (genvar i = 0; i < WORD_W; i++) begin : g_cmp
        localparam syn_t COL = word_col(i);
        assign hit[i] = (syn_i == COL);
    end

    always_comb begin
        pos_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (hit[i]) pos_o = pos_t'(i);
        end
    end

    assign flip_o = hit;
    assign corr_o = |hit;
    assign unc_o  = (syn_i != '0) && !(|hit);

endmodule

// File: rtl/ecc72_fix.sv
module ecc72_fix
    import ecc72_pkg::*;
(
    input  data_t data_i,
    input  data_t flip_i,
    output data_t data_o
);

    assign data_o = data_i ^ flip_i;

endmodule

// File: rtl/ecc72_decoder.sv
module ecc72_decoder
    import ecc72_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [71:0] in_word,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic        out_corr,
    output logic        out_uncorr,
    output logic [7:0]  out_syndrome,
    output logic [6:0]  out_pos
);

    syn_t       syn_w;
    word_t      flip_w;
    pos_t       pos_w;
    logic       corr_w;
    logic       unc_w;
    data_t      fixed_w;
    dec_state_t state_d, state_q;

    ecc72_syndrome u_syn (
        .word_i (in_word),
        .syn_o  (syn_w)
    );

    ecc72_locate u_loc (
        .syn_i  (syn_w),
        .flip_o (flip_w),
        .pos_o  (pos_w),
        .corr_o (corr_w),
        .unc_o  (unc_w)
    );

    ecc72_fix u_fix (
        .data_i (in_word[DATA_W-1:0]),
        .flip_i (flip_w[DATA_W-1:0]),
        .data_o (fixed_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.data = fixed_w;
            state_d.corr = corr_w;
            state_d.unc  = unc_w;
            state_d.syn  = syn_w;
            state_d.pos  = pos_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid    = state_q.vld;
    assign out_data     = state_q.data;
    assign out_corr     = state_q.corr;
    assign out_uncorr   = state_q.unc;
    assign out_syndrome = state_q.syn;
    assign out_pos      = state_q.pos;

    // Columns must be distinct: at most one position can match a syndrome (R5, R6).
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_w));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corr && out_uncorr));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_syndrome)));

    assert_clean_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_syndrome == '0) |-> (!out_corr && !out_uncorr && out_pos == '0));

    assert_raw_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_uncorr || out_data == $past(in_word[DATA_W-1:0])));

    assert_one_bit_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((!out_corr || out_pos >= pos_t'(DATA_W))
                      || $countones(out_data ^ $past(in_word[DATA_W-1:0])) == 1));

    assert_check_fix_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((!out_corr || out_pos < pos_t'(DATA_W))
                      || out_data == $past(in_word[DATA_W-1:0])));

endmodule

// File: tb/ecc72_decoder_tb.sv
`timescale 1ns/1ps
module ecc72_decoder_tb;

    localparam logic [7:0] TB_COL [64] = '{
        8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
        8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
        8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
        8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
        8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
        8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [71:0] in_word;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_corr;
    logic        out_uncorr;
    logic [7:0]  out_syndrome;
    logic [6:0]  out_pos;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ecc72_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_corr     (out_corr),
        .out_uncorr   (out_uncorr),
        .out_syndrome (out_syndrome),
        .out_pos      (out_pos)
    );

    function automatic logic [7:0] col_of(input int i);
        if (i < 64) return TB_COL[i];
        return 8'h80 >> (i - 64);
    endfunction

    function automatic logic [71:0] make_word(input logic [63:0] d);
        logic [7:0] s = '0;
        logic [71:0] w;
        for (int i = 0; i < 64; i++) if (d[i]) s ^= TB_COL[i];
        w[63:0] = d;
        for (int j = 0; j < 8; j++) w[64+j] = s[7-j];
        return w;
    endfunction

    // Expected {valid, data, corr, unc, syn, pos}
    function automatic logic [81:0] predict(input logic [71:0] w);
        logic [7:0]  s = '0;
        logic [63:0] d = w[63:0];
        logic        c = 1'b0;
        logic        u = 1'b0;
        logic [6:0]  p = '0;
        for (int i = 0; i < 72; i++) if (w[i]) s ^= col_of(i);
        if (s != 0) begin
            for (int i = 0; i < 72; i++) begin
                if (col_of(i) == s) begin
                    c = 1'b1;
                    p = 7'(i);
                    if (i < 64) d[i] = ~d[i];
                end
            end
            u = !c;
        end
        return {1'b1, d, c, u, s, p};
    endfunction

    function automatic logic [81:0] observed();
        return {out_valid, out_data, out_corr, out_uncorr, out_syndrome, out_pos};
    endfunction

    task automatic check(input string tag, input logic [81:0] got, input logic [81:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [71:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_word(input string tag, input logic [71:0] w);
        send(w);
        check(tag, observed(), predict(w));
    endtask

    initial begin
        logic [63:0] pats [6];
        logic [71:0] cw;
        logic [81:0] held;
        pats[0] = 64'h0;
        pats[1] = '1;
        pats[2] = 64'h0101010101010101;
        pats[3] = 64'ha5a5a5a55a5a5a5a;
        pats[4] = 64'h0123456789abcdef;
        pats[5] = 64'h8000000000000001;

        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_word  = '0;
        repeat (3) @(negedge clk);
        check("R9 reset state", observed(), '0);
        rst_n = 1'b1;

        for (int p = 0; p < 6; p++) begin
            cw = make_word(pats[p]);
            send(cw);
            check("R3 clean syndrome zero", {74'b0, out_syndrome}, 82'b0);
            check("R4 clean pass", observed(), {1'b1, pats[p], 1'b0, 1'b0, 8'h00, 7'd0});
            for (int i = 0; i < 72; i++) begin
                run_word(i < 64 ? "R5 data bit flip" : "R6 check bit flip", cw ^ (72'd1 << i));
                if (i < 64)
                    check("R2 data column", {74'b0, out_syndrome}, {74'b0, TB_COL[i]});
                else
                    check("R1 check column", {74'b0, out_syndrome}, {74'b0, 8'h80 >> (i - 64)});
            end
        end

        for (int p = 2; p < 4; p++) begin
            cw = make_word(pats[p]);
            for (int i = 0; i < 72; i++) begin
                for (int j = i + 1; j < 72; j++) begin
                    run_word("R7 double flip", cw ^ (72'd1 << i) ^ (72'd1 << j));
                    check("R7 double flagged", {80'b0, out_corr, out_uncorr}, {80'b0, 2'b01});
                end
            end
        end

        cw = make_word(64'h0101010101010101);
        send(cw ^ 72'h1);
        check("R10 bit0 repair", observed(),
              {1'b1, 64'h0101010101010101, 1'b1, 1'b0, 8'hf4, 7'd0});
        send(cw ^ 72'he);
        check("R7 triple flip", observed(),
              {1'b1, 64'h010101010101010f, 1'b0, 1'b1, 8'hf7, 7'd0});

        send(cw ^ (72'd1 << 40));
        held = observed();
        @(negedge clk);
        in_word = make_word(64'hdeadbeefcafef00d) ^ 72'h3;
        @(negedge clk);
        check("R8 idle hold", observed(), {1'b0, held[80:0]});
        send(cw);
        check("R8 valid after idle", observed(), {1'b1, 64'h0101010101010101, 2'b00, 8'h00, 7'd0});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule